// File: doc/BRIEF.md
# Index-Base Effective Address Generator

This block turns the operand fields of a memory-reference instruction into a memory address. Each instruction carries a 3-bit index field, a 3-bit base field, a displacement and a mode bit. The block reads the selected index and base registers from an external integer register file through two combinational read ports. It then forms a byte address, a half-byte select bit, an operand-type code and an alignment error flag. Instructions are accepted on a valid/ready handshake, and results leave on a second valid/ready handshake.

When the base field is zero, the block switches to array addressing. The pointer register is treated as the start of a table of array addresses. The block reads one table entry over an external request/response port and adds the index after that read. A mode bit selects 12-bit addressing. In that mode the base register still holds a byte address, but the offset is counted in 12-bit units, so the result is a nybble address. The block holds one instruction at a time. It carries no data.

Top module: `eaddr_gen`

## Requirements
- R1: An index field of 0 adds nothing to the address, whatever the register file returns. Index values 1 to 7 add integer register 1 to 7.
- R2: With the mode bit low and a nonzero base field b, the address is register (24+b) plus the index value plus the displacement with its two low bits cleared, taken modulo 2^32. The nybble select is 0.
- R3: `out_dtype` equals the two low displacement bits: 0 byte, 1 halfword, 2 word, 3 doubleword.
- R4: `out_err` is 1 exactly when the index value is not a multiple of the operand size (1, 2, 4 or 8 bytes). The address is still delivered.
- R5: A base field of 0 selects array mode. The block issues one table read at pointer plus cleared displacement, where the pointer is register 24 in normal mode and register 16 in 12-bit mode. In normal mode the result is the returned entry plus the index value.
- R6: With the mode bit high and a nonzero base field b, the nybble address N is 2 × register (16+b) + 3 × (index value + cleared displacement), modulo 2^33. `out_addr` is N shifted right by one, and `out_nyb` is bit 0 of N.
- R7: In array mode with the mode bit high, N is 2 × entry + 3 × index value, and N is split the same way as in R6.
- R8: While a result is held without `out_ready`, the result stays stable. While that result waits, or while a table lookup is in progress, `in_ready` is low.
- R9: A table request stays asserted with a stable address until `tbl_req_ready`. It drops in the next cycle, and each array-mode instruction gets exactly one request.
- R10: After reset, `out_valid` and `tbl_req_valid` are low and `in_ready` is high.
- R11: An instruction that is not in array mode produces `out_valid` in the cycle after it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Instruction accepted when high with in_valid |
| in_alt | input | 1 | 1 selects 12-bit unit addressing |
| in_idx | input | 3 | Index field |
| in_base | input | 3 | Base field, 0 selects array mode |
| in_disp | input | DISP_W | Displacement, low two bits give operand type |
| rf_idx_addr | output | 5 | Index register number |
| rf_idx_data | input | AW | Index register contents |
| rf_base_addr | output | 5 | Base or table-pointer register number |
| rf_base_data | input | AW | Base register contents |
| tbl_req_valid | output | 1 | Table read request |
| tbl_req_ready | input | 1 | Table request taken |
| tbl_req_addr | output | AW | Table entry byte address |
| tbl_rsp_valid | input | 1 | Table entry returned |
| tbl_rsp_data | input | AW | Table entry (array start address) |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Result consumed |
| out_addr | output | AW | Byte address |
| out_nyb | output | 1 | Half-byte select, 12-bit mode only |
| out_dtype | output | 2 | Operand type code |
| out_err | output | 1 | Index breaks operand alignment |

## Verification
The stimulus is random: register contents, displacements and field values are drawn at random, and both mode settings are mixed with array and direct bases. This separates the four address paths from each other and shows that the 12-bit path uses the doubled base and the tripled offset. Directed cases check several corners. One has a zero index field while register 0 holds a nonzero value, which shows that the index is ignored. Others carry sums past 2^32 and 2^33 to show the wrap, or use odd index values with each operand size to separate aligned accesses from misaligned ones. Further cases hold back `out_ready` and `tbl_req_ready`. They show that results and requests stay stable and that no second instruction slips in.

// File: rtl/eag_pkg.sv
package eag_pkg;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_REQ = 2'd1, ST_WAIT = 2'd2} eag_state_e;

  typedef enum logic [1:0] {
    DT_BYTE = 2'd0, DT_HALF = 2'd1, DT_WORD = 2'd2, DT_DOUBLE = 2'd3
  } eag_dtype_e;

  typedef struct packed {
    logic       alt;
    logic [1:0] dtype;
    logic       err;
  } eag_ctx_t;

  // index low bits vs operand size
  function automatic logic misaligned(input logic [2:0] low, input logic [1:0] dt);
    logic [2:0] mask;
    mask = 3'((4'd1 << dt) - 4'd1);
    return |(low & mask);
  endfunction
endpackage

// File: rtl/eag_regsel.sv
module eag_regsel #(
  parameter int FLD_W = 3,
  localparam int RN_W = FLD_W + 2
) (
  input  logic             alt,
  input  logic [FLD_W-1:0] idx,
  input  logic [FLD_W-1:0] base,
  output logic [RN_W-1:0]  idx_reg,
  output logic [RN_W-1:0]  base_reg,
  output logic             is_array
);
  // normal bases: 24..31, 12-bit bases: 16..23; field 0 gives the table pointer
  assign idx_reg  = {2'b00, idx};
  assign base_reg = {1'b1, ~alt, base};
  assign is_array = (base == '0);
endmodule

// File: rtl/eag_math.sv
module eag_math #(
  parameter int AW = 32
) (
  input  logic          alt,
  input  logic [AW-1:0] basev,
  input  logic [AW-1:0] off,
  output logic [AW-1:0] addr,
  output logic          nyb
);
  logic [AW:0] n_sum;

  // nybble address = 2*base + 3*off, wraps at 2^(AW+1)
  assign n_sum = {basev, 1'b0} + {1'b0, off} + {off, 1'b0};

  always_comb begin
    if (alt) begin
      addr = n_sum[AW:1];
      nyb  = n_sum[0];
    end else begin
      addr = basev + off;
      nyb  = 1'b0;
    end
  end
endmodule

// File: rtl/eaddr_gen.sv
module eaddr_gen #(
  parameter int AW     = 32,
  parameter int DISP_W = 16,
  parameter int FLD_W  = 3,
  localparam int RN_W  = FLD_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_alt,
  input  logic [FLD_W-1:0]  in_idx,
  input  logic [FLD_W-1:0]  in_base,
  input  logic [DISP_W-1:0] in_disp,
  output logic [RN_W-1:0]   rf_idx_addr,
  input  logic [AW-1:0]     rf_idx_data,
  output logic [RN_W-1:0]   rf_base_addr,
  input  logic [AW-1:0]     rf_base_data,
  output logic              tbl_req_valid,
  input  logic              tbl_req_ready,
  output logic [AW-1:0]     tbl_req_addr,
  input  logic              tbl_rsp_valid,
  input  logic [AW-1:0]     tbl_rsp_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [AW-1:0]     out_addr,
  output logic              out_nyb,
  output logic [1:0]        out_dtype,
  output logic              out_err
);
  import eag_pkg::*;

  eag_state_e    state;
  eag_ctx_t      ctx;
  logic [AW-1:0] ctx_idx;
  logic          is_array;
  logic          accept;
  logic [AW-1:0] idx_val;
  logic [AW-1:0] disp_al;
  logic          m_alt;
  logic [AW-1:0] m_base;
  logic [AW-1:0] m_off;
  logic [AW-1:0] m_addr;
  logic          m_nyb;
  logic          mis_now;

  eag_regsel #(.FLD_W(FLD_W)) u_sel (
    .alt      (in_alt),
    .idx      (in_idx),
    .base     (in_base),
    .idx_reg  (rf_idx_addr),
    .base_reg (rf_base_addr),
    .is_array (is_array)
  );

  assign in_ready = (state == ST_IDLE) && (!out_valid || out_ready);
  assign accept   = in_valid && in_ready;
  assign idx_val  = (in_idx == '0) ? '0 : rf_idx_data;
  assign disp_al  = {{(AW-DISP_W){1'b0}}, in_disp[DISP_W-1:2], 2'b00};
  assign mis_now  = misaligned(idx_val[2:0], in_disp[1:0]);

  // one arithmetic path, shared by direct and post-table phases
  always_comb begin
    if (state == ST_WAIT) begin
      m_alt  = ctx.alt;
      m_base = tbl_rsp_data;
      m_off  = ctx_idx;
    end else begin
      m_alt  = in_alt;
      m_base = rf_base_data;
      m_off  = idx_val + disp_al;
    end
  end

  eag_math #(.AW(AW)) u_math (
    .alt   (m_alt),
    .basev (m_base),
    .off   (m_off),
    .addr  (m_addr),
    .nyb   (m_nyb)
  );

  // control with reset
  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      out_valid     <= 1'b0;
      tbl_req_valid <= 1'b0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      unique case (state)
        ST_IDLE: if (accept) begin
          if (is_array) begin
            tbl_req_valid <= 1'b1;
            state         <= ST_REQ;
          end else begin
            out_valid <= 1'b1;
          end
        end
        ST_REQ: if (tbl_req_ready) begin
          tbl_req_valid <= 1'b0;
          state         <= ST_WAIT;
        end
        ST_WAIT: if (tbl_rsp_valid) begin
          out_valid <= 1'b1;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // datapath registers, no reset
  always_ff @(posedge clk) begin
    if (state == ST_IDLE && accept) begin
      if (is_array) begin
        tbl_req_addr <= rf_base_data + disp_al;
        ctx_idx      <= idx_val;
        ctx.alt      <= in_alt;
        ctx.dtype    <= in_disp[1:0];
        ctx.err      <= mis_now;
      end else begin
        out_addr  <= m_addr;
        out_nyb   <= m_nyb;
        out_dtype <= in_disp[1:0];
        out_err   <= mis_now;
      end
    end else if (state == ST_WAIT && tbl_rsp_valid) begin
      out_addr  <= m_addr;
      out_nyb   <= m_nyb;
      out_dtype <= ctx.dtype;
      out_err   <= ctx.err;
    end
  end
endmodule

// File: rtl/eaddr_gen_chk.sv
module eaddr_gen_chk #(
  parameter int AW = 32,
  parameter int FLD_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic [FLD_W-1:0] in_base,
  input logic             tbl_req_valid,
  input logic             tbl_req_ready,
  input logic [AW-1:0]    tbl_req_addr,
  input logic             out_valid,
  input logic             out_ready,
  input logic [AW-1:0]    out_addr,
  input logic             out_nyb,
  input logic [1:0]       out_dtype,
  input logic             out_err
);
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_nyb)
      && $stable(out_dtype) && $stable(out_err));

  p_busy_r8: assert property (@(posedge clk) disable iff (rst)
    tbl_req_valid |-> !in_ready);

  p_req_hold_r9: assert property (@(posedge clk) disable iff (rst)
    tbl_req_valid && !tbl_req_ready |=> tbl_req_valid && $stable(tbl_req_addr));

  p_req_drop_r9: assert property (@(posedge clk) disable iff (rst)
    tbl_req_valid && tbl_req_ready |=> !tbl_req_valid);

  p_reset_r10: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid && !tbl_req_valid && in_ready);

  p_lat_r11: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && in_base != '0 |=> out_valid);

  p_byte_ok_r4: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_dtype == 2'd0 |-> !out_err);
endmodule

bind eaddr_gen eaddr_gen_chk #(.AW(AW), .FLD_W(FLD_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .in_valid      (in_valid),
  .in_ready      (in_ready),
  .in_base       (in_base),
  .tbl_req_valid (tbl_req_valid),
  .tbl_req_ready (tbl_req_ready),
  .tbl_req_addr  (tbl_req_addr),
  .out_valid     (out_valid),
  .out_ready     (out_ready),
  .out_addr      (out_addr),
  .out_nyb       (out_nyb),
  .out_dtype     (out_dtype),
  .out_err       (out_err)
);

// File: tb/sim_eaddr_gen.sv
`timescale 1ns/1ps
module sim_eaddr_gen;
  localparam int AW = 32;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_alt = 1'b0;
  logic [2:0] in_idx = '0, in_base = '0;
  logic [DW-1:0] in_disp = '0;
  logic [4:0] rf_idx_addr, rf_base_addr;
  logic [AW-1:0] rf_idx_data, rf_base_data;
  logic tbl_req_valid, tbl_req_ready = 1'b0;
  logic [AW-1:0] tbl_req_addr;
  logic tbl_rsp_valid = 1'b0;
  logic [AW-1:0] tbl_rsp_data = '0;
  logic out_valid, out_ready = 1'b0, out_nyb, out_err, in_ready;
  logic [AW-1:0] out_addr;
  logic [1:0] out_dtype;

  logic [AW-1:0] regs [32];
  int n_chk = 0, n_fail = 0, cyc = 0;

  always #5 clk = ~clk;
  assign rf_idx_data  = regs[rf_idx_addr];
  assign rf_base_data = regs[rf_base_addr];

  eaddr_gen #(.AW(AW), .DISP_W(DW)) u0 (.*);

  function automatic logic [AW-1:0] tbl_f(input logic [AW-1:0] a);
    return a * 32'h9E37_79B1 + 32'd7;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run(input bit alt, input logic [2:0] idx, input logic [2:0] base,
                     input logic [DW-1:0] disp, input int hold, input int req_wait);
    logic [AW-1:0] iv, da, bv, ta, ea, xa;
    logic [AW:0] n33;
    logic xn, xe;
    iv = (idx == 0) ? '0 : regs[idx];
    da = {{(AW-DW){1'b0}}, disp[DW-1:2], 2'b00};
    bv = regs[(alt ? 16 : 24) + base];
    xe = ((iv[2:0] & 3'((4'd1 << disp[1:0]) - 4'd1)) != 0);
    ta = bv + da;
    ea = tbl_f(ta);
    if (base != 0) begin
      n33 = {bv, 1'b0} + 33'(3) * {1'b0, iv + da};
      xa = alt ? n33[AW:1] : bv + iv + da;
    end else begin
      n33 = {ea, 1'b0} + 33'(3) * {1'b0, iv};
      xa = alt ? n33[AW:1] : ea + iv;
    end
    xn = alt ? n33[0] : 1'b0;
    @(negedge clk);
    in_valid = 1'b1; in_alt = alt; in_idx = idx; in_base = base; in_disp = disp;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    if (base == 0) begin
      chk(tbl_req_valid && tbl_req_addr == ta, "R5 table address", tbl_req_addr, ta);
      chk(!in_ready, "R8 busy during lookup", in_ready, 0);
      for (int i = 0; i < req_wait; i++) begin
        @(negedge clk);
        chk(tbl_req_valid && tbl_req_addr == ta, "R9 request held", tbl_req_addr, ta);
      end
      tbl_req_ready = 1'b1;
      @(negedge clk);
      tbl_req_ready = 1'b0;
      chk(!tbl_req_valid, "R9 single request", tbl_req_valid, 0);
      tbl_rsp_valid = 1'b1; tbl_rsp_data = ea;
      @(negedge clk);
      tbl_rsp_valid = 1'b0;
      chk(!tbl_req_valid, "R9 no second request", tbl_req_valid, 0);
    end
    chk(out_valid, "R11 result valid", out_valid, 1);
    chk(out_addr == xa, alt ? (base == 0 ? "R7 alt array addr" : "R6 alt addr")
                            : (base == 0 ? "R5 array addr" : "R2 direct addr"), out_addr, xa);
    chk(out_nyb == xn, alt ? "R6 nybble select" : "R2 nybble zero", out_nyb, xn);
    chk(out_dtype == disp[1:0], "R3 type code", out_dtype, disp[1:0]);
    chk(out_err == xe, "R4 alignment flag", out_err, xe);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk(out_valid && out_addr == xa && !in_ready, "R8 held result", out_addr, xa);
    end
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk(!out_valid, "R8 result consumed", out_valid, 0);
  endtask

  task automatic rnd_regs();
    for (int i = 0; i < 32; i++) regs[i] = $urandom;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_chk++; n_fail++;
        $display("FAIL R8 watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rnd_regs();
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    chk(!out_valid && !tbl_req_valid && in_ready, "R10 reset state",
        {out_valid, tbl_req_valid, in_ready}, 3'b001);
    // R1: index field 0 ignores register 0
    regs[0] = 32'h0000_1235;
    regs[26] = 32'h1000_0000;
    run(1'b0, 3'd0, 3'd2, 16'h0104, 0, 0);
    // R2 wrap modulo 2^32
    regs[25] = 32'hFFFF_FFF0; regs[3] = 32'h8;
    run(1'b0, 3'd3, 3'd1, 16'h0043, 2, 0);
    // R4 misaligned double / halfword; byte never misaligned
    regs[5] = 32'h0000_0013;
    run(1'b0, 3'd5, 3'd4, 16'h0003, 0, 0);
    run(1'b0, 3'd5, 3'd4, 16'h0001, 0, 0);
    run(1'b0, 3'd5, 3'd4, 16'h0000, 0, 0);
    // R6 wrap modulo 2^33
    regs[23] = 32'hFFFF_FFFF; regs[7] = 32'h5555_5555;
    run(1'b1, 3'd7, 3'd7, 16'hFFFE, 1, 0);
    // R5 / R7 array modes, with request backpressure
    run(1'b0, 3'd2, 3'd0, 16'h0022, 0, 2);
    run(1'b1, 3'd6, 3'd0, 16'h0010, 3, 1);
    run(1'b1, 3'd0, 3'd0, 16'h0ABD, 0, 0);
    for (int t = 0; t < 300; t++) begin
      rnd_regs();
      run(1'($urandom), 3'($urandom), 3'($urandom & ($urandom % 3 == 0 ? 0 : 7)),
          16'($urandom), int'($urandom % 3), int'($urandom % 3));
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule